// File: doc/BRIEF.md
# Wavefront Issue Arbiter for a Four-SIMD Compute Unit

This block chooses, every cycle, which wavefronts of a compute unit issue an instruction and which wavefront gets the single instruction-fetch slot. The unit holds four SIMD groups with ten wavefront slots each. The scoreboard stage presents, for every slot, a ready flag, the class of the next instruction and an age stamp. A smaller stamp means an older wavefront, and equal stamps go to the lower slot index. For each SIMD the arbiter finds the oldest eligible wavefront. That wavefront fixes the instruction class for the cycle. The arbiter then gathers up to `ISSUE_W` wavefronts of that class, oldest first, and each wavefront appears at most once.

Branch and vector-ALU instructions run on the SIMD's sixteen-lane vector pipe, which needs four cycles per 64-item wavefront. The arbiter holds a per-SIMD occupancy count and keeps those two classes out while the pipe is busy. The other classes still issue during that time. Fetch arbitration rotates among the SIMDs. A wavefront whose instruction buffer already holds a branch does not request fetch.

Both outputs are valid/ready streams. A SIMD's issue group is accepted only in a cycle where its `iss_valid` and `iss_ready` are both high. Without acceptance nothing changes state, and the group is recomputed from the inputs of the next cycle. The fetch grant works the same way with `fetch_valid`/`fetch_ready`. The rotation pointer moves only on an accepted grant.

Top module: `wave_issue_arb`

## Requirements
- R1: After reset the vector pipes are free and the fetch rotation starts at SIMD 0. With no ready wavefronts and no fetch requests, every `iss_valid` and `fetch_valid` is low.
- R2: A wavefront is eligible to issue only if its ready bit is set and its class code is legal: 0 branch, 1 vector ALU, 2 vector memory, 3 local-share, 4 export, 5 special. Codes 6 and 7 never issue.
- R3: A SIMD's `iss_class` equals the class of its oldest eligible wavefront (smallest age, lower slot index on a tie).
- R4: The issue mask of a SIMD holds min(`ISSUE_W`, number of eligible wavefronts of the chosen class) distinct slots, all of that class, taken in age order. Mask bit w is slot w.
- R5: `iss_valid` of a SIMD is high exactly when that SIMD has at least one eligible wavefront.
- R6: An accepted group that contains branch or vector-ALU work takes the SIMD's vector pipe for `PIPE_CYC` cycles per unit, counting the issue cycle. Each vector-ALU instruction and each uniform branch is one unit. A divergent branch is two units. During that time classes 0 and 1 are not eligible, and classes 2 to 5 are unaffected.
- R7: A group offered without `iss_ready` leaves the pipe occupancy unchanged.
- R8: A wavefront requests fetch only when its fetch-request bit is set and its buffer-holds-branch bit is clear. `fetch_valid` is high exactly when some wavefront requests fetch.
- R9: The fetch grant goes to the first requesting SIMD found by searching upward (with wrap) from the rotation pointer. After an accepted grant the pointer moves to the SIMD after the granted one. Otherwise it stays.
- R10: Within the granted SIMD, `fetch_wf` names the oldest requesting slot (smallest age, lower index on a tie).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wf_ready | input | 40 | Ready flag per wavefront slot, slot s*10+w |
| wf_class | input | 120 | 3-bit class code per slot |
| wf_age | input | 160 | 4-bit age stamp per slot, smaller is older |
| wf_diverge | input | 40 | Slot's pending branch is divergent |
| wf_fetch_req | input | 40 | Slot wants an instruction fetch |
| wf_ib_branch | input | 40 | Slot's instruction buffer holds a branch |
| iss_valid | output | 4 | Issue group offered, per SIMD |
| iss_ready | input | 4 | Issue group accepted, per SIMD |
| iss_class | output | 12 | 3-bit class of each SIMD's group |
| iss_mask | output | 40 | Issuing slots, 10 bits per SIMD |
| fetch_valid | output | 1 | Fetch grant offered |
| fetch_ready | input | 1 | Fetch unit takes the grant |
| fetch_simd | output | 2 | Granted SIMD |
| fetch_wf | output | 4 | Granted slot within that SIMD |

## Verification
The assertions assume only that the scoreboard inputs settle before each clock edge. They make no assumption about ages, class codes, divergence flags or how the handshakes behave. The stimulus therefore draws illegal class codes 6 and 7, repeated age stamps, and independent random back-pressure on each issue port and on the fetch port. Directed sequences cover the exact cycle counts of pipe occupancy for vector ALU and divergent branches, a held offer, and a fetch blocked by a buffered branch.

// File: rtl/wfarb_pkg.sv
package wfarb_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_BRANCH  = 3'd0,
    CLS_VALU    = 3'd1,
    CLS_VMEM    = 3'd2,
    CLS_LDS     = 3'd3,
    CLS_EXPORT  = 3'd4,
    CLS_SPECIAL = 3'd5
  } wf_class_e;

  function automatic logic cls_legal(input logic [CLS_W-1:0] c);
    return c <= CLS_SPECIAL;
  endfunction

  function automatic logic cls_uses_pipe(input logic [CLS_W-1:0] c);
    return (c == CLS_BRANCH) || (c == CLS_VALU);
  endfunction
endpackage

// File: rtl/wf_age_pick.sv
module wf_age_pick #(
  parameter int unsigned N     = 10,
  parameter int unsigned AGE_W = 4
) (
  input  logic [N-1:0]       cand,
  input  logic [N*AGE_W-1:0] ages,
  output logic [N-1:0]       onehot
);
  logic             found;
  logic [AGE_W-1:0] best;

  // strict compare keeps the lower index on equal ages
  always_comb begin
    found  = 1'b0;
    best   = '0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || ages[i*AGE_W +: AGE_W] < best)) begin
        found     = 1'b1;
        best      = ages[i*AGE_W +: AGE_W];
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/simd_issue_sel.sv
module simd_issue_sel import wfarb_pkg::*; #(
  parameter int unsigned WF       = 10,
  parameter int unsigned ISSUE_W  = 2,
  parameter int unsigned AGE_W    = 4,
  parameter int unsigned PIPE_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WF-1:0]       ready,
  input  logic [WF*CLS_W-1:0] cls,
  input  logic [WF*AGE_W-1:0] age,
  input  logic [WF-1:0]       div,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [CLS_W-1:0]    iss_class,
  output logic [WF-1:0]       iss_mask
);
  localparam int unsigned UNIT_W = $clog2(2*ISSUE_W + 1);
  localparam int unsigned OCC_W  = $clog2(PIPE_CYC*2*ISSUE_W + 1);

  logic [OCC_W-1:0]  pipe_cnt;
  logic              pipe_busy;
  logic [WF-1:0]     elig;
  logic [WF-1:0]     match;
  logic [WF-1:0]     lead_oh;
  logic [CLS_W-1:0]  lead_cls;
  logic [WF-1:0]     taken [ISSUE_W+1];
  logic [WF-1:0]     pick  [ISSUE_W];
  logic [UNIT_W-1:0] units;
  logic [OCC_W-1:0]  occ;
  logic              hs;

  assign pipe_busy = (pipe_cnt != '0);

  always_comb begin
    for (int w = 0; w < WF; w++) begin
      elig[w] = ready[w] && cls_legal(cls[w*CLS_W +: CLS_W]) &&
                !(pipe_busy && cls_uses_pipe(cls[w*CLS_W +: CLS_W]));
    end
  end

  wf_age_pick #(.N(WF), .AGE_W(AGE_W)) u_lead (
    .cand(elig), .ages(age), .onehot(lead_oh)
  );

  always_comb begin
    lead_cls = '0;
    for (int w = 0; w < WF; w++)
      if (lead_oh[w]) lead_cls = cls[w*CLS_W +: CLS_W];
  end

  always_comb begin
    for (int w = 0; w < WF; w++)
      match[w] = elig[w] && (cls[w*CLS_W +: CLS_W] == lead_cls);
  end

  assign taken[0] = '0;
  for (genvar r = 0; r < ISSUE_W; r++) begin : g_round
    wf_age_pick #(.N(WF), .AGE_W(AGE_W)) u_pick (
      .cand(match & ~taken[r]), .ages(age), .onehot(pick[r])
    );
    assign taken[r+1] = taken[r] | pick[r];
  end

  assign iss_mask  = taken[ISSUE_W];
  assign iss_valid = |iss_mask;
  assign iss_class = lead_cls;
  assign hs        = iss_valid && iss_ready;

  always_comb begin
    units = '0;
    for (int w = 0; w < WF; w++) begin
      if (iss_mask[w]) begin
        if (cls[w*CLS_W +: CLS_W] == CLS_VALU)
          units = units + UNIT_W'(1);
        else if (cls[w*CLS_W +: CLS_W] == CLS_BRANCH)
          units = units + (div[w] ? UNIT_W'(2) : UNIT_W'(1));
      end
    end
    occ = OCC_W'(PIPE_CYC) * OCC_W'(units);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pipe_cnt <= '0;
    else if (hs && occ != '0)
      pipe_cnt <= occ - OCC_W'(1);
    else if (pipe_busy)
      pipe_cnt <= pipe_cnt - OCC_W'(1);
  end

  p_group_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_mask) <= ISSUE_W);
  p_mask_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_mask & ~ready) == '0);
  p_legal_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> cls_legal(iss_class));
  p_pipe_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_busy && iss_valid) |-> !cls_uses_pipe(iss_class));
  p_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_busy && !hs) |=> !pipe_busy);
  for (genvar w = 0; w < WF; w++) begin : g_chk
    p_same_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_mask[w] |-> (cls[w*CLS_W +: CLS_W] == iss_class));
  end
endmodule

// File: rtl/fetch_rr_arb.sv
module fetch_rr_arb #(
  parameter int unsigned NS    = 4,
  parameter int unsigned WF    = 10,
  parameter int unsigned AGE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS*WF-1:0]       req,
  input  logic [NS*WF*AGE_W-1:0] age,
  output logic                   fetch_valid,
  input  logic                   fetch_ready,
  output logic [((NS > 1) ? $clog2(NS) : 1)-1:0] fetch_simd,
  output logic [((WF > 1) ? $clog2(WF) : 1)-1:0] fetch_wf
);
  localparam int unsigned SIDX_W = (NS > 1) ? $clog2(NS) : 1;
  localparam int unsigned WIDX_W = (WF > 1) ? $clog2(WF) : 1;

  logic [SIDX_W-1:0] ptr;
  logic [SIDX_W-1:0] sel;
  logic [NS-1:0]     any;
  logic [WF-1:0]     oh [NS];

  for (genvar s = 0; s < NS; s++) begin : g_simd
    assign any[s] = |req[s*WF +: WF];
    wf_age_pick #(.N(WF), .AGE_W(AGE_W)) u_pick (
      .cand(req[s*WF +: WF]), .ages(age[s*WF*AGE_W +: WF*AGE_W]), .onehot(oh[s])
    );
  end

  always_comb begin
    fetch_valid = 1'b0;
    sel         = '0;
    for (int k = 0; k < NS; k++) begin
      int s;
      s = (int'(ptr) + k) % NS;
      if (!fetch_valid && any[s]) begin
        fetch_valid = 1'b1;
        sel         = SIDX_W'(s);
      end
    end
  end

  always_comb begin
    fetch_wf = '0;
    for (int w = 0; w < WF; w++)
      if (oh[sel][w]) fetch_wf = WIDX_W'(w);
  end

  assign fetch_simd = sel;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (fetch_valid && fetch_ready)
      ptr <= (sel == SIDX_W'(NS-1)) ? '0 : sel + SIDX_W'(1);
  end

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> $stable(ptr));
  p_grant_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> any[fetch_simd]);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !fetch_valid);
endmodule

// File: rtl/wave_issue_arb.sv
module wave_issue_arb import wfarb_pkg::*; #(
  parameter int unsigned NUM_SIMD    = 4,
  parameter int unsigned WF_PER_SIMD = 10,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned AGE_W       = 4,
  parameter int unsigned PIPE_CYC    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_ready,
  input  logic [NUM_SIMD*WF_PER_SIMD*3-1:0]     wf_class,
  input  logic [NUM_SIMD*WF_PER_SIMD*AGE_W-1:0] wf_age,
  input  logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_diverge,
  input  logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_fetch_req,
  input  logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_ib_branch,
  output logic [NUM_SIMD-1:0]                   iss_valid,
  input  logic [NUM_SIMD-1:0]                   iss_ready,
  output logic [NUM_SIMD*3-1:0]                 iss_class,
  output logic [NUM_SIMD*WF_PER_SIMD-1:0]       iss_mask,
  output logic                                  fetch_valid,
  input  logic                                  fetch_ready,
  output logic [((NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1)-1:0]       fetch_simd,
  output logic [((WF_PER_SIMD > 1) ? $clog2(WF_PER_SIMD) : 1)-1:0] fetch_wf
);
  localparam int unsigned WF     = WF_PER_SIMD;
  localparam int unsigned TOTAL  = NUM_SIMD * WF;
  localparam int unsigned FLAT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [TOTAL-1:0]  fetch_elig;
  logic [FLAT_W-1:0] fetch_flat;

  for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
    simd_issue_sel #(
      .WF(WF), .ISSUE_W(ISSUE_W), .AGE_W(AGE_W), .PIPE_CYC(PIPE_CYC)
    ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (wf_ready[s*WF +: WF]),
      .cls      (wf_class[s*WF*CLS_W +: WF*CLS_W]),
      .age      (wf_age[s*WF*AGE_W +: WF*AGE_W]),
      .div      (wf_diverge[s*WF +: WF]),
      .iss_valid(iss_valid[s]),
      .iss_ready(iss_ready[s]),
      .iss_class(iss_class[s*CLS_W +: CLS_W]),
      .iss_mask (iss_mask[s*WF +: WF])
    );
  end

  assign fetch_elig = wf_fetch_req & ~wf_ib_branch;

  fetch_rr_arb #(.NS(NUM_SIMD), .WF(WF), .AGE_W(AGE_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (fetch_elig),
    .age        (wf_age),
    .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready),
    .fetch_simd (fetch_simd),
    .fetch_wf   (fetch_wf)
  );

  always_comb fetch_flat = FLAT_W'(fetch_simd) * FLAT_W'(WF) + FLAT_W'(fetch_wf);

  p_fetch_elig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (wf_fetch_req[fetch_flat] && !wf_ib_branch[fetch_flat]));
  p_fetch_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_wf < WF));
endmodule

// File: tb/wave_issue_arb_test.sv
module wave_issue_arb_test;
  localparam int NS = 4, WF = 10, N = 2, AW = 4, T = NS*WF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [T-1:0] wf_ready, wf_diverge, wf_fetch_req, wf_ib_branch, iss_mask;
  logic [T*3-1:0] wf_class;
  logic [T*AW-1:0] wf_age;
  logic [NS-1:0] iss_valid, iss_ready;
  logic [NS*3-1:0] iss_class;
  logic fetch_valid, fetch_ready;
  logic [1:0] fetch_simd;
  logic [3:0] fetch_wf;

  wave_issue_arb uut (.*);

  always #4 clk = ~clk;

  bit m_rdy[T], m_div[T], m_freq[T], m_ibb[T], m_issr[NS], m_fr;
  logic [2:0] m_cls[T];
  logic [3:0] m_age[T];
  int pipe_m[NS], ptr_m, checks = 0, errors = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < T; i++) begin
      m_rdy[i] = 0; m_div[i] = 0; m_freq[i] = 0; m_ibb[i] = 0; m_cls[i] = 0; m_age[i] = 0;
    end
    for (int s = 0; s < NS; s++) m_issr[s] = 1;
    m_fr = 0;
  endtask

  task automatic calc_issue(input int s, output bit v, output int c, output int mk);
    bit el[WF]; int lead = -1;
    for (int w = 0; w < WF; w++) begin
      int g = s*WF + w;
      el[w] = m_rdy[g] && m_cls[g] < 6 && !(pipe_m[s] > 0 && m_cls[g] < 2);
      if (el[w] && (lead < 0 || m_age[g] < m_age[s*WF+lead])) lead = w;
    end
    mk = 0; v = (lead >= 0); c = v ? int'(m_cls[s*WF+lead]) : 0;
    if (v) for (int k = 0; k < N; k++) begin
      int b = -1;
      for (int w = 0; w < WF; w++)
        if (el[w] && int'(m_cls[s*WF+w]) == c && !mk[w] &&
            (b < 0 || m_age[s*WF+w] < m_age[s*WF+b])) b = w;
      if (b >= 0) mk[b] = 1'b1;
    end
  endtask

  task automatic calc_fetch(output bit v, output int fs, output int fw);
    v = 0; fs = 0; fw = 0;
    for (int k = 0; k < NS; k++) begin
      int s = (ptr_m + k) % NS; int b = -1;
      for (int w = 0; w < WF; w++) begin
        int g = s*WF + w;
        if (m_freq[g] && !m_ibb[g] && (b < 0 || m_age[g] < m_age[s*WF+b])) b = w;
      end
      if (!v && b >= 0) begin v = 1; fs = s; fw = b; end
    end
  endtask

  task automatic step();
    bit v, fv; int c, mk, fs, fw;
    @(negedge clk);
    for (int i = 0; i < T; i++) begin
      wf_ready[i] = m_rdy[i]; wf_diverge[i] = m_div[i]; wf_fetch_req[i] = m_freq[i];
      wf_ib_branch[i] = m_ibb[i]; wf_class[i*3 +: 3] = m_cls[i]; wf_age[i*AW +: AW] = m_age[i];
    end
    for (int s = 0; s < NS; s++) iss_ready[s] = m_issr[s];
    fetch_ready = m_fr;
    #1;
    for (int s = 0; s < NS; s++) begin
      calc_issue(s, v, c, mk);
      chk("R5", "iss_valid", int'(iss_valid[s]), int'(v));
      if (v) begin
        chk("R3", "iss_class", int'(iss_class[s*3 +: 3]), c);
        chk("R4", "iss_mask", int'(iss_mask[s*WF +: WF]), mk);
      end
      if (v && m_issr[s]) begin
        int u = 0;
        for (int w = 0; w < WF; w++)
          if (mk[w]) begin
            if (m_cls[s*WF+w] == 1) u += 1;
            else if (m_cls[s*WF+w] == 0) u += m_div[s*WF+w] ? 2 : 1;
          end
        if (u > 0) pipe_m[s] = 4*u - 1;
        else if (pipe_m[s] > 0) pipe_m[s]--;
      end else if (pipe_m[s] > 0) pipe_m[s]--;
    end
    calc_fetch(fv, fs, fw);
    chk("R8", "fetch_valid", int'(fetch_valid), int'(fv));
    if (fv) begin
      chk("R9", "fetch_simd", int'(fetch_simd), fs);
      chk("R10", "fetch_wf", int'(fetch_wf), fw);
      if (m_fr) ptr_m = (fs + 1) % NS;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_all();
    for (int s = 0; s < NS; s++) pipe_m[s] = 0;
    ptr_m = 0;
    wf_ready = '0; wf_diverge = '0; wf_fetch_req = '0; wf_ib_branch = '0;
    wf_class = '0; wf_age = '0; iss_ready = '0; fetch_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle after reset, rotation begins at SIMD 0
    step();
    chk("R1", "iss_valid idle", int'(iss_valid), 0);
    chk("R1", "fetch_valid idle", int'(fetch_valid), 0);
    for (int i = 0; i < T; i++) m_freq[i] = 1;
    step();
    chk("R1", "first fetch simd", int'(fetch_simd), 0);

    // R2: illegal class codes never issue
    clear_all();
    m_rdy[13] = 1; m_cls[13] = 6; m_rdy[14] = 1; m_cls[14] = 7;
    step();
    chk("R2", "illegal codes valid", int'(iss_valid[1]), 0);
    m_rdy[15] = 1; m_cls[15] = 2; m_age[15] = 9;
    step();
    chk("R2", "legal among illegal mask", int'(iss_mask[10 +: WF]), 1 << 5);

    // R6: vector ALU occupancy and unaffected local-share issue
    clear_all();
    m_rdy[0] = 1; m_cls[0] = 1; m_age[0] = 5;
    step(); chk("R6", "valu issue", int'(iss_mask[0 +: WF]), 1);
    step(); chk("R6", "valu blocked c1", int'(iss_valid[0]), 0);
    m_rdy[1] = 1; m_cls[1] = 3; m_age[1] = 1;
    step(); chk("R6", "lds during busy", int'(iss_mask[0 +: WF]), 2);
    m_rdy[1] = 0;
    step(); chk("R6", "valu blocked c3", int'(iss_valid[0]), 0);
    step(); chk("R6", "valu free c4", int'(iss_mask[0 +: WF]), 1);
    m_rdy[0] = 0;
    repeat (4) step();

    // R6: divergent branch holds the pipe for two units
    m_rdy[2] = 1; m_cls[2] = 0; m_div[2] = 1;
    step(); chk("R6", "div branch issue", int'(iss_mask[0 +: WF]), 4);
    m_rdy[2] = 0; m_rdy[0] = 1;
    for (int k = 1; k < 8; k++) begin
      step(); chk("R6", "div branch blocked", int'(iss_valid[0]), 0);
    end
    step(); chk("R6", "div branch free", int'(iss_mask[0 +: WF]), 1);
    m_rdy[0] = 0;
    repeat (4) step();

    // R7: offer without acceptance leaves pipe free
    m_rdy[0] = 1; m_issr[0] = 0;
    step(); chk("R7", "held offer", int'(iss_valid[0]), 1);
    m_issr[0] = 1;
    step(); chk("R7", "reissue next cycle", int'(iss_mask[0 +: WF]), 1);
    m_rdy[0] = 0;
    repeat (4) step();

    // R8: buffered branch suppresses fetch
    clear_all();
    m_freq[20] = 1; m_ibb[20] = 1;
    step(); chk("R8", "ib branch blocks", int'(fetch_valid), 0);
    m_ibb[20] = 0;
    step(); chk("R8", "fetch after clear", int'(fetch_simd)*16 + int'(fetch_wf), 2*16);

    // R4: group of two oldest of the leading class
    clear_all();
    m_rdy[37] = 1; m_cls[37] = 2; m_age[37] = 0;
    m_rdy[32] = 1; m_cls[32] = 2; m_age[32] = 3;
    m_rdy[34] = 1; m_cls[34] = 2; m_age[34] = 3;
    m_rdy[31] = 1; m_cls[31] = 3; m_age[31] = 1;
    m_rdy[39] = 1; m_cls[39] = 1; m_age[39] = 2;
    step();
    chk("R3", "lead class", int'(iss_class[9 +: 3]), 2);
    chk("R4", "age ordered group", int'(iss_mask[30 +: WF]), (1 << 7) | (1 << 2));

    // R9/R10: rotation under random traffic with back-pressure
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int dense = (cyc / 200) % 2;
      for (int i = 0; i < T; i++) begin
        m_rdy[i]  = dense ? ($urandom_range(0, 2) != 0) : ($urandom_range(0, 7) == 0);
        m_cls[i]  = 3'($urandom_range(0, 7));
        m_age[i]  = 4'($urandom_range(0, 7));
        m_div[i]  = ($urandom_range(0, 3) == 0);
        m_freq[i] = ($urandom_range(0, 5) == 0);
        m_ibb[i]  = ($urandom_range(0, 2) == 0);
      end
      for (int s = 0; s < NS; s++) m_issr[s] = ($urandom_range(0, 3) != 0);
      m_fr = ($urandom_range(0, 1) != 0);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule